// File: doc/BRIEF.md
# Display panel power sequencer

This block orders the bring-up and tear-down of a display panel link, so that the panel never shows noise, garbage pixels or a lit backlight over an undefined image. It drives five control lines: the panel supply enable, the active-low power-down of the link serializer, the video source enable, the select that forces the pixel mux to black, and the backlight enable. Two status lines report when the link is fully on or fully off.

A single level request starts the sequence. When the request goes high, the block turns on panel supply and waits for the supply ramp. It then waits a further settle time, releases the serializer from power-down, and starts the video source with forced black for a lock interval. After that it selects real pixels and lights the backlight last. When the request goes low, the block turns the backlight off and waits. It then forces black and holds it for a set number of frame-start strobes. Next it puts the serializer back into power-down, stops the video source, and finally removes panel supply. The four wait lengths are clock-cycle counts supplied on input ports. The number of black frames is a build parameter.

A sequence is never cut short. A change of the request during a sequence is acted on only once the sequence has reached its fully-on or fully-off state.

Top module: `panel_pwr_seq`

## Requirements
- R1: During and directly after reset, panel_pwr_en, ser_pd_n, video_en, bl_en and link_on are 0, while force_black and link_off are 1.
- R2: `en_req` is registered once. On the second rising edge after `en_req` is seen high in the fully-off state, panel_pwr_en rises with every other output unchanged. It then stays in the ramp step for max(ramp_cycles,1) cycles.
- R3: After the ramp step, a settle step of max(settle_cycles,1) cycles keeps the same outputs. Then ser_pd_n rises alone for exactly one cycle before video_en rises.
- R4: video_en rises with force_black still 1, and black is held for max(lock_cycles,1) cycles. Then force_black falls, and the backlight stays off for one further cycle.
- R5: bl_en rises one cycle after force_black falls. link_on is 1 in exactly the cycles where bl_en is 1.
- R6: On the second rising edge after `en_req` is seen low in the fully-on state, bl_en falls, and force_black stays 0 for max(bl_off_cycles,1) cycles.
- R7: force_black then rises, and black is held until the BLACK_FRAMES-th `frame_start` pulse (default 3) seen while black is held. Pulses during the backlight-off wait are not counted. ser_pd_n falls one cycle after that pulse.
- R8: video_en falls one cycle after ser_pd_n falls, and panel_pwr_en falls one cycle after that. At that point link_off becomes 1.
- R9: A wait count of 0 behaves exactly like a count of 1: the step lasts one cycle.
- R10: A change of `en_req` during either sequence changes no output of that sequence. The new level is acted on right after the fully-on or fully-off state is reached, with that state lasting one cycle.
- R11: link_on and link_off are both 0 in every intermediate step and never 1 together. The fully-on and fully-off states hold while the request is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Level request: 1 = link on, 0 = link off |
| frame_start | input | 1 | One-cycle pulse at the start of each video frame |
| ramp_cycles | input | CNT_W | Supply ramp wait in cycles |
| settle_cycles | input | CNT_W | Extra settle wait before power-down release |
| lock_cycles | input | CNT_W | Black interval for link lock after video start |
| bl_off_cycles | input | CNT_W | Wait after backlight off before forcing black |
| panel_pwr_en | output | 1 | Panel supply enable |
| ser_pd_n | output | 1 | Serializer power-down, active low |
| video_en | output | 1 | Video source enable |
| force_black | output | 1 | Pixel mux black select |
| bl_en | output | 1 | Backlight enable |
| link_on | output | 1 | Link fully on |
| link_off | output | 1 | Link fully off |

## Verification
The bench sweeps every combination of the four wait counts over 0, 1 and 2, and compares all seven outputs with an arithmetic prediction on every cycle. A wrong dwell off-by-one, or a zero count handled as a long wrap-around wait, shows up as a step boundary one cycle early or late. Frame pulses run throughout, including during the backlight-off wait, so a counter that starts early or counts one pulse too few releases power-down before its predicted edge. Requests that flip mid-sequence in both directions catch a design that aborts a sequence or drops the latched request, because ON or OFF would then last longer than one cycle or never be reached.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_RAMP, S_SETTLE, S_PDUP, S_LOCK, S_IMG, S_ON,
    S_BLOFF, S_BLACK, S_PDDN, S_VOFF
  } pps_state_e;

  typedef struct packed {
    logic pwr;
    logic pdn;
    logic vid;
    logic blk;
    logic bl;
  } pps_out_t;

  // Output pattern of each step; every step changes one line.
  function automatic pps_out_t pps_decode(pps_state_e s);
    pps_out_t o;
    o = '{pwr: 1'b0, pdn: 1'b0, vid: 1'b0, blk: 1'b1, bl: 1'b0};
    unique case (s)
      S_OFF:            ;
      S_RAMP, S_SETTLE: o.pwr = 1'b1;
      S_PDUP:           begin o.pwr = 1'b1; o.pdn = 1'b1; end
      S_LOCK, S_BLACK:  begin o.pwr = 1'b1; o.pdn = 1'b1; o.vid = 1'b1; end
      S_IMG, S_BLOFF:   begin o.pwr = 1'b1; o.pdn = 1'b1; o.vid = 1'b1; o.blk = 1'b0; end
      S_ON:             begin o.pwr = 1'b1; o.pdn = 1'b1; o.vid = 1'b1; o.blk = 1'b0; o.bl = 1'b1; end
      S_PDDN:           begin o.pwr = 1'b1; o.vid = 1'b1; end
      S_VOFF:           o.pwr = 1'b1;
      default:          ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pps_dwell_timer.sv
module pps_dwell_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  // A step has lasted long enough once cnt+1 cycles reach the limit;
  // a limit of zero is therefore met in the first cycle.
  function automatic logic reached(logic [CNT_W-1:0] c, logic [CNT_W-1:0] l);
    return ({1'b0, c} + (CNT_W+1)'(1)) >= {1'b0, l};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  assign done = reached(cnt, limit);

  a_r9_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (done == (limit <= CNT_W'(1))));

endmodule

// File: rtl/pps_frame_count.sv
module pps_frame_count #(
  parameter int FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic strobe,
  output logic done
);

  localparam int FW = (FRAMES < 1) ? 1 : $clog2(FRAMES + 1);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FW-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  fcnt <= '0;
    else if (clear)                              fcnt <= '0;
    else if (active && strobe && fcnt != LAST)   fcnt <= fcnt + FW'(1);
  end

  assign done = active && strobe && (fcnt == LAST);

  a_r7_frames_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (fcnt <= LAST));

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int BLACK_FRAMES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] ramp_cycles,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic [CNT_W-1:0] lock_cycles,
  input  logic [CNT_W-1:0] bl_off_cycles,
  output logic             panel_pwr_en,
  output logic             ser_pd_n,
  output logic             video_en,
  output logic             force_black,
  output logic             bl_en,
  output logic             link_on,
  output logic             link_off
);

  pps_state_e       state, state_nxt;
  pps_out_t         out_q;
  logic             req_q;
  logic             on_q, off_q;
  logic [CNT_W-1:0] dwell_lim;
  logic             step_enter;
  logic             wait_done;
  logic             frames_done;
  logic             in_black;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= en_req;
  end

  always_comb begin
    unique case (state)
      S_RAMP:   dwell_lim = ramp_cycles;
      S_SETTLE: dwell_lim = settle_cycles;
      S_LOCK:   dwell_lim = lock_cycles;
      S_BLOFF:  dwell_lim = bl_off_cycles;
      default:  dwell_lim = '0;
    endcase
  end

  assign step_enter = (state_nxt != state);
  assign in_black   = (state == S_BLACK);

  pps_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step_enter),
    .limit   (dwell_lim),
    .done    (wait_done)
  );

  pps_frame_count #(.FRAMES(BLACK_FRAMES)) u_frames (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (step_enter),
    .active (in_black),
    .strobe (frame_start),
    .done   (frames_done)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      S_OFF:    if (req_q)       state_nxt = S_RAMP;
      S_RAMP:   if (wait_done)   state_nxt = S_SETTLE;
      S_SETTLE: if (wait_done)   state_nxt = S_PDUP;
      S_PDUP:                    state_nxt = S_LOCK;
      S_LOCK:   if (wait_done)   state_nxt = S_IMG;
      S_IMG:                     state_nxt = S_ON;
      S_ON:     if (!req_q)      state_nxt = S_BLOFF;
      S_BLOFF:  if (wait_done)   state_nxt = S_BLACK;
      S_BLACK:  if (frames_done) state_nxt = S_PDDN;
      S_PDDN:                    state_nxt = S_VOFF;
      S_VOFF:                    state_nxt = S_OFF;
      default:                   state_nxt = S_OFF;
    endcase
  end

  // Outputs come straight from flops, loaded with the next step's pattern.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      out_q <= pps_decode(S_OFF);
      on_q  <= 1'b0;
      off_q <= 1'b1;
    end else begin
      state <= state_nxt;
      out_q <= pps_decode(state_nxt);
      on_q  <= (state_nxt == S_ON);
      off_q <= (state_nxt == S_OFF);
    end
  end

  assign panel_pwr_en = out_q.pwr;
  assign ser_pd_n     = out_q.pdn;
  assign video_en     = out_q.vid;
  assign force_black  = out_q.blk;
  assign bl_en        = out_q.bl;
  assign link_on      = on_q;
  assign link_off     = off_q;

  a_r3_pdn_after_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_pd_n) |-> $past(panel_pwr_en) && !video_en);

  a_r3_video_after_pdn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(video_en) |-> $past(ser_pd_n) && force_black);

  a_r4_black_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_black) |-> $past(wait_done) && video_en && !bl_en);

  a_r5_backlight_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(!force_black) && ser_pd_n && video_en && panel_pwr_en);

  a_r6_backlight_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bl_en) |-> !force_black && video_en && ser_pd_n);

  a_r7_pdn_after_frames: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_pd_n) |-> $past(frames_done) && force_black);

  a_r8_video_off_after_pdn: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(video_en) |-> $past(!ser_pd_n) && panel_pwr_en);

  a_r8_supply_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_pwr_en) |-> $past(!video_en) && link_off);

  a_r10_no_abort_up: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAMP) |=> (state == S_RAMP || state == S_SETTLE));

  a_r10_no_abort_down: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLACK) |=> (state == S_BLACK || state == S_PDDN));

  a_r11_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_on && link_off));

endmodule

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;

  localparam int N_FR = 3;
  localparam int FP   = 3;

  // {pwr, pdn, vid, blk, bl, on, off}
  localparam logic [6:0] V_OFF   = 7'b0001001;
  localparam logic [6:0] V_RAMP  = 7'b1001000;
  localparam logic [6:0] V_PDUP  = 7'b1101000;
  localparam logic [6:0] V_LOCK  = 7'b1111000;
  localparam logic [6:0] V_IMG   = 7'b1110000;
  localparam logic [6:0] V_ON    = 7'b1110110;
  localparam logic [6:0] V_PDDN  = 7'b1011000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0;
  logic frame_start = 1'b0;
  logic [15:0] ramp_cycles = '0, settle_cycles = '0, lock_cycles = '0, bl_off_cycles = '0;
  logic panel_pwr_en, ser_pd_n, video_en, force_black, bl_en, link_on, link_off;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  panel_pwr_seq #(.CNT_W(16), .BLACK_FRAMES(N_FR)) dut (
    .clk, .rst_n, .en_req, .frame_start,
    .ramp_cycles, .settle_cycles, .lock_cycles, .bl_off_cycles,
    .panel_pwr_en, .ser_pd_n, .video_en, .force_black, .bl_en,
    .link_on, .link_off
  );

  function automatic int dw(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(logic [6:0] expv, string tag);
    logic [6:0] got;
    got = {panel_pwr_en, ser_pd_n, video_en, force_black, bl_en, link_on, link_off};
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, expv);
    end
  endtask

  task automatic hold(logic [6:0] expv, int n);
    frame_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check(expv, "R11");
    end
  endtask

  // Up sequence; lead = edges until the ramp step appears.
  task automatic run_up(int lead, bit flip);
    int d1, d2, d3, total, s;
    logic [6:0] e;
    string tag;
    d1 = dw(int'(ramp_cycles)); d2 = dw(int'(settle_cycles)); d3 = dw(int'(lock_cycles));
    total = lead + d1 + d2 + d3 + 2;
    if (lead == 2) en_req = 1'b1;
    frame_start = ((1 % FP) == 0);
    for (int t = 1; t <= total; t++) begin
      @(posedge clk); @(negedge clk);
      s = t - lead;
      if (s < 0)                    begin e = V_OFF;  tag = "R2"; end
      else if (s < d1)              begin e = V_RAMP; tag = (ramp_cycles == 0) ? "R9" : "R2"; end
      else if (s < d1 + d2)         begin e = V_RAMP; tag = (settle_cycles == 0) ? "R9" : "R3"; end
      else if (s == d1 + d2)        begin e = V_PDUP; tag = "R3"; end
      else if (s < d1 + d2 + 1 + d3) begin e = V_LOCK; tag = (lock_cycles == 0) ? "R9" : "R4"; end
      else if (s == d1 + d2 + 1 + d3) begin e = V_IMG; tag = "R4"; end
      else                          begin e = V_ON;   tag = "R5"; end
      if (flip) tag = "R10";
      check(e, tag);
      frame_start = (((t + 1) % FP) == 0);
      if (flip && t == 1) en_req = 1'b0;
    end
  endtask

  // Down sequence; frame pulses arrive before every edge that is a multiple of FP.
  task automatic run_down(int lead, bit flip);
    int d4, tb0, e1, en, s;
    logic [6:0] e;
    string tag;
    d4  = dw(int'(bl_off_cycles));
    tb0 = lead + d4;
    e1  = (tb0 / FP + 1) * FP;
    en  = e1 + (N_FR - 1) * FP;
    if (lead == 2) en_req = 1'b0;
    frame_start = ((1 % FP) == 0);
    for (int t = 1; t <= en + 2; t++) begin
      @(posedge clk); @(negedge clk);
      s = t - lead;
      if (s < 0)            begin e = V_ON;   tag = "R6"; end
      else if (s < d4)      begin e = V_IMG;  tag = (bl_off_cycles == 0) ? "R9" : "R6"; end
      else if (t < en)      begin e = V_LOCK; tag = "R7"; end
      else if (t == en)     begin e = V_PDDN; tag = "R7"; end
      else if (t == en + 1) begin e = V_RAMP; tag = "R8"; end
      else                  begin e = V_OFF;  tag = "R8"; end
      if (flip) tag = "R10";
      check(e, tag);
      frame_start = (((t + 1) % FP) == 0);
      if (flip && t == 1) en_req = 1'b1;
    end
  endtask

  task automatic set_delays(int a, int b, int c, int d);
    ramp_cycles = 16'(a); settle_cycles = 16'(b);
    lock_cycles = 16'(c); bl_off_cycles = 16'(d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(V_OFF, "R1");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(V_OFF, "R1");

    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++) begin
            set_delays(a, b, c, d);
            run_up(2, 1'b0);
            hold(V_ON, 3);
            run_down(2, 1'b0);
            hold(V_OFF, 3);
          end

    set_delays(5, 3, 7, 4);
    run_up(2, 1'b0);
    hold(V_ON, 2);
    run_down(2, 1'b0);
    hold(V_OFF, 2);

    // R10: request withdrawn during bring-up, then raised during tear-down
    set_delays(2, 1, 3, 2);
    run_up(2, 1'b1);
    run_down(1, 1'b0);
    hold(V_OFF, 2);
    run_up(2, 1'b0);
    run_down(2, 1'b1);
    run_up(1, 1'b0);
    hold(V_ON, 2);
    run_down(2, 1'b0);
    hold(V_OFF, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired: got hung run expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule